// File: doc/BRIEF.md
# Duplex Lockstep Fault Supervisor

This block watches two processors that execute the same program in lockstep and decides, every cycle, whether their shared result may leave the module. It checks the two bus outputs against each other. It also gathers fault indicators from neighbouring blocks, and these arrive as two-rail pairs. The first fault sends the pair into a timed recovery window and pulses a restart. A second fault inside that window halts both processors and silences the module bus.

A halted module stays halted until an external master issues a command. The master can resume duplex operation, or it can run the module on either processor alone with the cross-compare switched off. The state and the accumulated fault causes are always visible on status outputs, including after shutdown. Bus arbitration is represented only by a grant input that qualifies the output valid.

Top module: `dual_lockstep_guard`

## Requirements
- R1: After reset the state reads RUN (`state_o` = 0), `halt_o` = 2'b00, `restart_o` = 0, `cause_o` = 3'b000 and `mod_vld` = 0. State codes: 0 RUN, 1 RECOVER, 2 HALTED, 3 DEGRADED.
- R2: In RUN, a compare mismatch moves the state to RECOVER on the next edge. A mismatch means the two valids differ, or both are valid with different data. `restart_o` is high during exactly the first RECOVER cycle, and `cause_o` bit 0 is set.
- R3: A valid external fault on any pair moves the state from RUN to RECOVER just as a mismatch does, and sets `cause_o` bit 1. A valid fault is `flt_t[i]`=1 with `flt_f[i]`=0; the healthy code is 0/1.
- R4: `mod_vld` = `grant` & valid of the selected processor. It is forced low in RECOVER and HALTED, and also in any cycle where a fault is being seen. `mod_dat` carries the selected processor's data while `mod_vld` is high, and zero otherwise.
- R5: With no further fault, RECOVER lasts `win_len`+1 cycles and then returns to RUN, which resets the retry budget.
- R6: A mismatch or a valid external fault during RECOVER moves the state to HALTED, where `halt_o` = 2'b11.
- R7: If any pair has equal rails (00 or 11), the state goes straight to HALTED from any other state, with no retry, and `cause_o` bit 2 is set.
- R8: In HALTED, faults, data and grant have no effect. Only a command leaves it.
- R9: Commands (`cmd_vld` with `cmd`) are accepted in HALTED: 01 resumes RUN, 10 enters DEGRADED on processor A, and 11 enters DEGRADED on processor B. In DEGRADED, 01 returns to RUN. An accepted command clears `cause_o` and pulses `restart_o` for the first cycle of the new state.
- R10: In DEGRADED, the unused processor is halted (`halt_o` bit 0 = A, bit 1 = B). The output comes from the selected processor, and the cross-compare is ignored.
- R11: In DEGRADED, a valid external fault or a rail disagreement moves the state to HALTED.
- R12: Commands received in RUN or RECOVER have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_dat | input | DW | Processor A bus data |
| a_vld | input | 1 | Processor A bus valid |
| b_dat | input | DW | Processor B bus data |
| b_vld | input | 1 | Processor B bus valid |
| flt_t | input | NFLT | True rail of each external fault pair |
| flt_f | input | NFLT | False rail of each external fault pair |
| grant | input | 1 | Bus grant from arbitration |
| win_len | input | WINW | Recovery window length minus one, in cycles |
| cmd | input | 2 | Master command code |
| cmd_vld | input | 1 | Command strobe |
| mod_dat | output | DW | Module bus data |
| mod_vld | output | 1 | Module bus valid |
| restart_o | output | 1 | Rollback/restart pulse to the processors |
| halt_o | output | 2 | Halt per processor (bit 0 = A) |
| state_o | output | 2 | Current supervisor state |
| cause_o | output | 3 | Sticky causes: bit 0 compare, bit 1 external, bit 2 rail |

## Verification
The bench targets the window boundary. A fault in the last RECOVER cycle must halt the module, and a window of zero must last exactly one cycle; an off-by-one counter would either forgive a recurrence or return early. It also drives mismatches that differ only in valid, which an inexact comparator would let slip onto the bus. Rail disagreements are sent in both RUN and DEGRADED, where a design that treats them as ordinary faults would retry instead of halting. Commands are issued in RUN and RECOVER, where a loose decoder would wrongly switch to single-processor operation.

// File: rtl/dual_lockstep_guard.sv
module dual_lockstep_guard #(
  parameter int DW     = 32,
  parameter int NFLT   = 4,
  parameter int WINW   = 16,
  parameter bit DEG_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   a_dat,
  input  logic            a_vld,
  input  logic [DW-1:0]   b_dat,
  input  logic            b_vld,
  input  logic [NFLT-1:0] flt_t,
  input  logic [NFLT-1:0] flt_f,
  input  logic            grant,
  input  logic [WINW-1:0] win_len,
  input  logic [1:0]      cmd,
  input  logic            cmd_vld,
  output logic [DW-1:0]   mod_dat,
  output logic            mod_vld,
  output logic            restart_o,
  output logic [1:0]      halt_o,
  output logic [1:0]      state_o,
  output logic [2:0]      cause_o
);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_REC = 2'd1, S_HALT = 2'd2, S_DEG = 2'd3} st_e;

  st_e             st_q, st_d;
  logic [WINW-1:0] cnt_q;
  logic            dsel_q, dsel_d;
  logic            rst_d;
  logic            take;
  logic            rail_t_q, rail_f_q;
  logic [2:0]      cause_q;

  wire duplex  = (st_q == S_RUN) || (st_q == S_REC);
  wire active  = (st_q != S_HALT);
  wire cmp_err = duplex && ((a_vld ^ b_vld) || (a_vld && b_vld && (a_dat != b_dat)));
  wire ext_hit = |(flt_t & ~flt_f);
  wire ext_bad = |(~(flt_t ^ flt_f));

  wire cmp_dup  = duplex && !((a_vld == b_vld) && (!a_vld || (a_dat == b_dat)));
  wire ext_dup  = ~&(~flt_t | flt_f);
  wire rail_err = (rail_t_q == rail_f_q);

  wire chk_err = ext_bad || rail_err;
  wire flt     = cmp_err || ext_hit;

  always_comb begin
    st_d   = st_q;
    dsel_d = dsel_q;
    rst_d  = 1'b0;
    take   = 1'b0;
    unique case (st_q)
      S_RUN: begin
        if (chk_err) st_d = S_HALT;
        else if (flt) begin
          st_d  = S_REC;
          rst_d = 1'b1;
        end
      end
      S_REC: begin
        if (chk_err || flt) st_d = S_HALT;
        else if (cnt_q == '0) st_d = S_RUN;
      end
      S_HALT: begin
        if (cmd_vld && cmd == 2'b01) begin
          st_d  = S_RUN;
          rst_d = 1'b1;
          take  = 1'b1;
        end else if (cmd_vld && cmd[1] && DEG_EN) begin
          st_d   = S_DEG;
          dsel_d = cmd[0];
          rst_d  = 1'b1;
          take   = 1'b1;
        end
      end
      S_DEG: begin
        if (chk_err || ext_hit) st_d = S_HALT;
        else if (cmd_vld && cmd == 2'b01) begin
          st_d  = S_RUN;
          rst_d = 1'b1;
          take  = 1'b1;
        end
      end
      default: st_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_RUN;
      cnt_q     <= '0;
      dsel_q    <= 1'b0;
      restart_o <= 1'b0;
      rail_t_q  <= 1'b0;
      rail_f_q  <= 1'b1;
      cause_q   <= '0;
    end else begin
      st_q      <= st_d;
      dsel_q    <= dsel_d;
      restart_o <= rst_d;
      rail_t_q  <= active && flt;
      rail_f_q  <= !(active && (cmp_dup || ext_dup));
      if (st_q != S_REC && st_d == S_REC) cnt_q <= win_len;
      else if (st_q == S_REC && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (take) cause_q <= '0;
      else if (active) cause_q <= cause_q | {chk_err, ext_hit, cmp_err};
    end
  end

  wire          use_b   = (st_q == S_DEG) && dsel_q;
  wire [DW-1:0] sel_dat = use_b ? b_dat : a_dat;
  wire          sel_vld = use_b ? b_vld : a_vld;
  wire          out_en  = ((st_q == S_RUN) && !flt && !chk_err) ||
                          ((st_q == S_DEG) && !ext_hit && !chk_err);

  assign mod_vld = out_en && grant && sel_vld;
  assign mod_dat = mod_vld ? sel_dat : '0;
  assign state_o = st_q;
  assign cause_o = cause_q;
  assign halt_o  = (st_q == S_HALT) ? 2'b11 :
                   (st_q == S_DEG)  ? (dsel_q ? 2'b01 : 2'b10) : 2'b00;

  p_mismatch_recovers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && cmp_err && !chk_err) |=> (st_q == S_REC && restart_o));

  p_contain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_REC || st_q == S_HALT) |-> !mod_vld);

  p_recur_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_REC && (flt || chk_err)) |=> (st_q == S_HALT && halt_o == 2'b11));

  p_rail_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && chk_err) |=> (st_q == S_HALT));

  p_halt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_HALT && !cmd_vld) |=> (st_q == S_HALT && $stable(cause_q)));

  p_deg_one_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DEG) |-> $onehot0(halt_o) && halt_o != 2'b00);

  p_cmd_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && !flt && !chk_err) |=> (st_q == S_RUN));

endmodule

// File: tb/sim_dual_lockstep_guard.sv
`timescale 1ns/1ps
module sim_dual_lockstep_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_dat = '0, b_dat = '0, mod_dat;
  logic        a_vld = 1'b0, b_vld = 1'b0, grant = 1'b0, cmd_vld = 1'b0;
  logic [3:0]  flt_t = 4'h0, flt_f = 4'hF;
  logic [15:0] win_len = 16'd2;
  logic [1:0]  cmd = 2'b00;
  logic        mod_vld, restart_o;
  logic [1:0]  halt_o, state_o;
  logic [2:0]  cause_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_lockstep_guard u0 (
    .clk(clk), .rst_n(rst_n), .a_dat(a_dat), .a_vld(a_vld), .b_dat(b_dat), .b_vld(b_vld),
    .flt_t(flt_t), .flt_f(flt_f), .grant(grant), .win_len(win_len), .cmd(cmd), .cmd_vld(cmd_vld),
    .mod_dat(mod_dat), .mod_vld(mod_vld), .restart_o(restart_o), .halt_o(halt_o),
    .state_o(state_o), .cause_o(cause_o));

  // {ad[8], av, bd[8], bv, flt_t[4], flt_f[4], grant, cmd[2], cmd_vld, exp_mod_vld, exp_state[2]}
  localparam int NV = 21;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {8'h11,1'b1,8'h11,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b1,2'd0},  // R4 pass-through
    {8'h22,1'b1,8'h22,1'b1,4'h0,4'hF,1'b0,2'd0,1'b0,1'b0,2'd0},  // R4 no grant
    {8'h33,1'b1,8'h34,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd1},  // R2 data mismatch
    {8'h40,1'b1,8'h40,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd1},  // R5
    {8'h41,1'b1,8'h41,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd1},
    {8'h42,1'b1,8'h42,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd0},  // R5 back to RUN
    {8'h50,1'b1,8'h50,1'b0,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd1},  // R2 valid mismatch
    {8'h00,1'b0,8'h00,1'b0,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd1},
    {8'h00,1'b0,8'h00,1'b0,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd1},
    {8'h00,1'b0,8'h00,1'b0,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd0},
    {8'h60,1'b1,8'h60,1'b1,4'h1,4'hE,1'b1,2'd0,1'b0,1'b0,2'd1},  // R3 external fault
    {8'h61,1'b1,8'h62,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd2},  // R6 recurrence
    {8'h70,1'b1,8'h70,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd2},  // R8 stays halted
    {8'h71,1'b1,8'h71,1'b1,4'hF,4'hF,1'b1,2'd0,1'b0,1'b0,2'd2},  // R8 faults ignored
    {8'h00,1'b0,8'h00,1'b0,4'h0,4'hF,1'b1,2'd3,1'b1,1'b0,2'd3},  // R9 degraded on B
    {8'h55,1'b1,8'h66,1'b1,4'h0,4'hF,1'b1,2'd0,1'b0,1'b1,2'd3},  // R10 compare ignored
    {8'h55,1'b1,8'h66,1'b0,4'h0,4'hF,1'b1,2'd0,1'b0,1'b0,2'd3},  // R10 B valid drives
    {8'h00,1'b0,8'h00,1'b0,4'h2,4'hF,1'b1,2'd0,1'b0,1'b0,2'd2},  // R11 rail error
    {8'h00,1'b0,8'h00,1'b0,4'h0,4'hF,1'b1,2'd1,1'b1,1'b0,2'd0},  // R9 resume
    {8'h77,1'b1,8'h77,1'b1,4'h0,4'hF,1'b1,2'd2,1'b1,1'b1,2'd0},  // R12 cmd in RUN
    {8'h00,1'b0,8'h00,1'b0,4'h0,4'hB,1'b1,2'd0,1'b0,1'b0,2'd2}   // R7 rail 00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] ad, input logic av, input logic [7:0] bd, input logic bv,
                       input logic [3:0] et, input logic [3:0] ef, input logic [1:0] c, input logic cv);
    @(negedge clk);
    a_dat = {24'h0, ad}; a_vld = av; b_dat = {24'h0, bd}; b_vld = bv;
    flt_t = et; flt_f = ef; cmd = c; cmd_vld = cv; grant = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 state", state_o, 0);
    chk("R1 halt", halt_o, 0);
    chk("R1 restart", restart_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 mod_vld", mod_vld, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      a_dat = {24'h0, VEC[i][32:25]}; a_vld = VEC[i][24];
      b_dat = {24'h0, VEC[i][23:16]}; b_vld = VEC[i][15];
      flt_t = VEC[i][14:11]; flt_f = VEC[i][10:7]; grant = VEC[i][6];
      cmd = VEC[i][5:4]; cmd_vld = VEC[i][3];
      #1;
      chk($sformatf("R4 vec%0d mod_vld", i), mod_vld, VEC[i][2]);
      tick();
      chk($sformatf("R2-table vec%0d state", i), state_o, VEC[i][1:0]);
    end

    chk("R7 cause rail bit", cause_o, 3'b100);
    chk("R6 halt both", halt_o, 2'b11);

    drive(8'hAB, 1'b1, 8'hCD, 1'b1, 4'h0, 4'hF, 2'd2, 1'b1);
    tick();
    chk("R9 degraded A", state_o, 3);
    chk("R9 restart pulse", restart_o, 1);
    chk("R9 cause cleared", cause_o, 0);
    chk("R10 B halted", halt_o, 2'b10);
    drive(8'hAB, 1'b1, 8'hCD, 1'b1, 4'h0, 4'hF, 2'd0, 1'b0);
    #1;
    chk("R10 data from A", mod_dat, 32'hAB);
    chk("R10 valid", mod_vld, 1);
    tick();
    chk("R9 restart single", restart_o, 0);
    drive(8'h00, 1'b0, 8'h00, 1'b0, 4'h4, 4'hB, 2'd0, 1'b0);
    tick();
    chk("R11 external fault halts", state_o, 2);

    drive(8'h00, 1'b0, 8'h00, 1'b0, 4'h0, 4'hF, 2'd1, 1'b1);
    tick();
    chk("R9 resume", state_o, 0);
    win_len = 16'd0;
    drive(8'h10, 1'b1, 8'h11, 1'b1, 4'h0, 4'hF, 2'd0, 1'b0);
    #1;
    chk("R4 mismatch blocked", mod_vld, 0);
    tick();
    chk("R2 recover", state_o, 1);
    chk("R2 restart", restart_o, 1);
    chk("R2 cause cmp", cause_o, 3'b001);
    drive(8'h10, 1'b1, 8'h10, 1'b1, 4'h0, 4'hF, 2'd2, 1'b1);
    tick();
    chk("R5 window 0 one cycle", state_o, 0);
    chk("R12 cmd in RECOVER ignored", halt_o, 2'b00);

    win_len = 16'd3;
    drive(8'h20, 1'b0, 8'h20, 1'b1, 4'h0, 4'hF, 2'd0, 1'b0);
    tick();
    chk("R2 valid mismatch", state_o, 1);
    for (int k = 0; k < 3; k++) begin
      drive(8'h20, 1'b1, 8'h20, 1'b1, 4'h0, 4'hF, 2'd0, 1'b0);
      tick();
      chk("R5 still recovering", state_o, 1);
    end
    drive(8'h20, 1'b1, 8'h20, 1'b1, 4'h8, 4'h7, 2'd0, 1'b0);
    tick();
    chk("R6 fault in last window cycle", state_o, 2);
    chk("R3 cause ext", cause_o, 3'b011);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule